// File: doc/BRIEF.md
# CHR Upper Address and Nametable Mirroring Selector

This block sits beside a bank-switching controller on a cartridge and forms the upper pattern-memory address and the nametable mirroring choice. Each cycle it takes the controller's inner CHR bank outputs and its mirroring bits. It also takes a handful of outer configuration fields written by the multicart menu. From these it registers a 20-bit CHR address and a 2-bit mirroring code.

There are two paths that can bypass the inner controller. The first is an 8 KiB bank path: a 4-bit outer bank value replaces the inner bank bits for address lines 16..13. The second is a forced single-screen mode, in which the screen is picked by bit 4 of inner PRG bank register 6. The outer window sits above the inner one. Address line 17 is either taken from the inner controller (a 256 KiB window) or pinned by an outer bit (a 128 KiB window). Lines 19..18 always come from the outer fields, and a parameter swaps those two wires for the alternate board wiring. All outputs are registered once, so each output reflects the inputs of the previous clock edge.

Top module: `chr_mirror_sel`

## Requirements
- R1: While rst_n is low at a clock edge, chr_addr becomes 0 and mirror_sel becomes 0 (vertical) after that edge.
- R2: chr_addr[12:0] equals ppu_addr as sampled at the previous clock edge.
- R3: With use_8k_bank low, chr_addr[16:13] equals inner_chr_bank[3:0] of the previous edge.
- R4: With use_8k_bank high, chr_addr[16:13] equals bank_8k[3:0] of the previous edge, and inner_chr_bank[3:0] has no effect on it.
- R5: With a17_from_outer low, chr_addr[17] equals inner_chr_bank[4]; with it high, chr_addr[17] equals a17_outer_bit.
- R6: With SWAP_HI=0, chr_addr[19] equals outer_hi[1] and chr_addr[18] equals outer_hi[0]; with SWAP_HI=1 the two are exchanged.
- R7: With force_one_screen low and mirr_ext_en low, mirror_sel is 0 (vertical) when inner_mirr[0]=0 and 1 (horizontal) when inner_mirr[0]=1; inner_mirr[1] is ignored.
- R8: With force_one_screen low and mirr_ext_en high, inner_mirr[1]=1 selects single-screen: mirror_sel is 2 (low screen) for inner_mirr[0]=0 and 3 (high screen) for inner_mirr[0]=1; inner_mirr[1]=0 behaves as R7.
- R9: With force_one_screen high, mirror_sel is 2 when prg_r6_b4=0 and 3 when prg_r6_b4=1, regardless of inner_mirr and mirr_ext_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ppu_addr | input | 13 | Pattern address bits 12..0 from the video side |
| inner_chr_bank | input | 5 | Inner controller CHR bank outputs, lines 17..13 |
| inner_mirr | input | 2 | Inner mirroring register: bit 0 direction/screen, bit 1 single-screen request |
| a17_from_outer | input | 1 | Take line 17 from a17_outer_bit (128 KiB inner window) |
| a17_outer_bit | input | 1 | Outer value of line 17 |
| outer_hi | input | 2 | Outer values of lines 19..18 |
| mirr_ext_en | input | 1 | Let inner_mirr[1] request single-screen |
| bank_8k | input | 4 | Outer 8 KiB CHR bank number |
| use_8k_bank | input | 1 | Take lines 16..13 from bank_8k |
| force_one_screen | input | 1 | Force single-screen mirroring from prg_r6_b4 |
| prg_r6_b4 | input | 1 | Bit 4 of inner PRG bank register 6 |
| chr_addr | output | 20 | Registered CHR address, lines 19..0 |
| mirror_sel | output | 2 | Registered mirroring code: 0 vertical, 1 horizontal, 2 one-screen low, 3 one-screen high |

## Verification
The address path is driven with several patterns. Alternating and all-ones bank values show whether the inner and 8 KiB sources are picked per bit rather than merged. Lone set bits on the outer high pair show whether the two lines are swapped or crossed. Conflicting inner and outer values on line 17 show which source wins. The mirroring path is driven with every inner code under each of the three control settings, which separates the two-way mode from the extended mode. A forced single-screen case with inner bits that would mean something else shows that the bank-register bit overrides them.

// File: rtl/chrsel_pkg.sv
// Shared types for the CHR address / mirroring selector.
// Assumes a 2-bit mirroring code consumed by the nametable decoder.
package chrsel_pkg;
    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;
endpackage

// File: rtl/chrsel_bank_mux.sv
// Builds the inner CHR window (line 17 down to line 13).
// Lines 16..13 come from the inner controller or from the outer 8 KiB bank;
// line 17 comes from the inner controller or from an outer pin bit.
// Assumes the inner bank bus is one bit wider than the 8 KiB bank field.
module chrsel_bank_mux #(
    parameter int BANK8K_W = 4
) (
    input  logic [BANK8K_W:0]   inner_bank,
    input  logic                use_8k,
    input  logic [BANK8K_W-1:0] bank_8k,
    input  logic                top_from_outer,
    input  logic                top_outer_bit,
    output logic [BANK8K_W:0]   window
);
    // Pick each part of the window from its selected source.
    always_comb begin
        window[BANK8K_W-1:0] = use_8k ? bank_8k : inner_bank[BANK8K_W-1:0];
        window[BANK8K_W]     = top_from_outer ? top_outer_bit : inner_bank[BANK8K_W];
    end
endmodule

// File: rtl/chrsel_outer_hi.sv
// Routes the two outer high CHR lines, optionally exchanging them for the
// alternate board wiring. Pure wiring; the variant is fixed at elaboration.
module chrsel_outer_hi #(
    parameter bit SWAP_HI = 1'b0
) (
    input  logic [1:0] hi_in,
    output logic [1:0] hi_out
);
    generate
        if (SWAP_HI) begin : g_swapped
            // Exchange the two lines.
            always_comb hi_out = {hi_in[0], hi_in[1]};
        end else begin : g_straight
            // Pass the lines unchanged.
            always_comb hi_out = hi_in;
        end
    endgenerate
endmodule

// File: rtl/chrsel_mirror.sv
// Chooses the nametable mirroring code. A forced single-screen mode takes
// priority; otherwise the inner mirroring bits are decoded, with the
// single-screen request bit honoured only when extended mode is enabled.
module chrsel_mirror
    import chrsel_pkg::*;
(
    input  logic [1:0] inner_mirr,
    input  logic       ext_en,
    input  logic       force_one,
    input  logic       r6_b4,
    output mirror_e    mode
);
    // Priority decode of the mirroring source.
    always_comb begin
        if (force_one)
            mode = r6_b4 ? MIR_ONE_HI : MIR_ONE_LO;
        else if (ext_en && inner_mirr[1])
            mode = inner_mirr[0] ? MIR_ONE_HI : MIR_ONE_LO;
        else
            mode = inner_mirr[0] ? MIR_HORZ : MIR_VERT;
    end
endmodule

// File: rtl/chr_mirror_sel.sv
// Top of the CHR upper address and mirroring selector.
// Combines the inner window, the outer high lines and the pass-through low
// address, then registers the address and mirroring code once.
// Assumes a synchronous active-low reset; reset value is address 0, vertical.
module chr_mirror_sel
    import chrsel_pkg::*;
#(
    parameter int LOW_W    = 13,
    parameter int BANK8K_W = 4,
    parameter bit SWAP_HI  = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LOW_W-1:0]          ppu_addr,
    input  logic [BANK8K_W:0]         inner_chr_bank,
    input  logic [1:0]                inner_mirr,
    input  logic                      a17_from_outer,
    input  logic                      a17_outer_bit,
    input  logic [1:0]                outer_hi,
    input  logic                      mirr_ext_en,
    input  logic [BANK8K_W-1:0]       bank_8k,
    input  logic                      use_8k_bank,
    input  logic                      force_one_screen,
    input  logic                      prg_r6_b4,
    output logic [LOW_W+BANK8K_W+2:0] chr_addr,
    output logic [1:0]                mirror_sel
);
    localparam int WIN_W  = BANK8K_W + 1;
    localparam int ADDR_W = LOW_W + WIN_W + 2;

    logic [WIN_W-1:0]  win;
    logic [1:0]        hi;
    mirror_e           mir_next;
    logic [ADDR_W-1:0] addr_next;

    chrsel_bank_mux #(.BANK8K_W(BANK8K_W)) u_bank (
        .inner_bank     (inner_chr_bank),
        .use_8k         (use_8k_bank),
        .bank_8k        (bank_8k),
        .top_from_outer (a17_from_outer),
        .top_outer_bit  (a17_outer_bit),
        .window         (win)
    );

    chrsel_outer_hi #(.SWAP_HI(SWAP_HI)) u_hi (
        .hi_in  (outer_hi),
        .hi_out (hi)
    );

    chrsel_mirror u_mir (
        .inner_mirr (inner_mirr),
        .ext_en     (mirr_ext_en),
        .force_one  (force_one_screen),
        .r6_b4      (prg_r6_b4),
        .mode       (mir_next)
    );

    // Concatenate the full address from its three slices.
    always_comb addr_next = {hi, win, ppu_addr};

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chr_addr   <= '0;
            mirror_sel <= MIR_VERT;
        end else begin
            chr_addr   <= addr_next;
            mirror_sel <= mir_next;
        end
    end
endmodule

// File: rtl/chr_mirror_sel_chk.sv
// Checker for chr_mirror_sel: relates registered outputs to the inputs of the
// previous edge. Attached with the bind below.
module chr_mirror_sel_chk #(
    parameter int LOW_W    = 13,
    parameter int BANK8K_W = 4,
    parameter bit SWAP_HI  = 1'b0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [LOW_W-1:0]          ppu_addr,
    input logic [BANK8K_W:0]         inner_chr_bank,
    input logic [1:0]                inner_mirr,
    input logic                      a17_from_outer,
    input logic                      a17_outer_bit,
    input logic [1:0]                outer_hi,
    input logic                      mirr_ext_en,
    input logic [BANK8K_W-1:0]       bank_8k,
    input logic                      use_8k_bank,
    input logic                      force_one_screen,
    input logic                      prg_r6_b4,
    input logic [LOW_W+BANK8K_W+2:0] chr_addr,
    input logic [1:0]                mirror_sel
);
    localparam int TOP = LOW_W + BANK8K_W;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (chr_addr == '0 && mirror_sel == 2'd0)); // R1

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> chr_addr[LOW_W-1:0] == $past(ppu_addr)); // R2

    AST_INNER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(use_8k_bank)) |->
        chr_addr[TOP-1:LOW_W] == $past(inner_chr_bank[BANK8K_W-1:0])); // R3

    AST_OUTER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(use_8k_bank)) |->
        chr_addr[TOP-1:LOW_W] == $past(bank_8k)); // R4

    AST_A17_INNER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(a17_from_outer)) |->
        chr_addr[TOP] == $past(inner_chr_bank[BANK8K_W])); // R5

    AST_A17_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a17_from_outer)) |->
        chr_addr[TOP] == $past(a17_outer_bit)); // R5

    AST_HIGH_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> chr_addr[TOP+2:TOP+1] ==
        (SWAP_HI ? {$past(outer_hi[0]), $past(outer_hi[1])} : $past(outer_hi))); // R6

    AST_MIR_TWO_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(force_one_screen) && !$past(mirr_ext_en)) |->
        mirror_sel == {1'b0, $past(inner_mirr[0])}); // R7

    AST_MIR_EXT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(force_one_screen) && $past(mirr_ext_en) && $past(inner_mirr[1])) |->
        mirror_sel == {1'b1, $past(inner_mirr[0])}); // R8

    AST_MIR_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(force_one_screen)) |->
        mirror_sel == {1'b1, $past(prg_r6_b4)}); // R9
endmodule

bind chr_mirror_sel chr_mirror_sel_chk #(
    .LOW_W(LOW_W), .BANK8K_W(BANK8K_W), .SWAP_HI(SWAP_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .inner_chr_bank(inner_chr_bank),
    .inner_mirr(inner_mirr), .a17_from_outer(a17_from_outer), .a17_outer_bit(a17_outer_bit),
    .outer_hi(outer_hi), .mirr_ext_en(mirr_ext_en), .bank_8k(bank_8k),
    .use_8k_bank(use_8k_bank), .force_one_screen(force_one_screen), .prg_r6_b4(prg_r6_b4),
    .chr_addr(chr_addr), .mirror_sel(mirror_sel)
);

// File: tb/sim_chr_mirror_sel.sv
// Bench for chr_mirror_sel: a vector table walked by one loop, then directed
// reset and corner tests. Inputs change on the falling edge; outputs are
// sampled on the falling edge after the capturing rising edge.
module sim_chr_mirror_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [4:0]  inner_chr_bank = '0;
    logic [1:0]  inner_mirr = '0;
    logic        a17_from_outer = 1'b0;
    logic        a17_outer_bit = 1'b0;
    logic [1:0]  outer_hi = '0;
    logic        mirr_ext_en = 1'b0;
    logic [3:0]  bank_8k = '0;
    logic        use_8k_bank = 1'b0;
    logic        force_one_screen = 1'b0;
    logic        prg_r6_b4 = 1'b0;
    logic [19:0] chr_addr;
    logic [1:0]  mirror_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    chr_mirror_sel u0 (
        .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .inner_chr_bank(inner_chr_bank),
        .inner_mirr(inner_mirr), .a17_from_outer(a17_from_outer), .a17_outer_bit(a17_outer_bit),
        .outer_hi(outer_hi), .mirr_ext_en(mirr_ext_en), .bank_8k(bank_8k),
        .use_8k_bank(use_8k_bank), .force_one_screen(force_one_screen), .prg_r6_b4(prg_r6_b4),
        .chr_addr(chr_addr), .mirror_sel(mirror_sel)
    );

    typedef struct packed {
        logic [12:0] ppu;
        logic [4:0]  ib;
        logic [1:0]  im;
        logic        a17s;
        logic        a17b;
        logic [1:0]  hi;
        logic        ext;
        logic [3:0]  b8k;
        logic        u8k;
        logic        one;
        logic        r6;
        logic [19:0] exp_addr;
        logic [1:0]  exp_mir;
    } vec_t;

    // ppu, ib, im, a17s, a17b, hi, ext, b8k, u8k, one, r6, exp_addr, exp_mir
    localparam vec_t VECS [15] = '{
        '{13'h0000, 5'h00, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'h00000, 2'd0}, // R3 idle
        '{13'h1ABC, 5'h15, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'h2BABC, 2'd1}, // R3 R7
        '{13'h0FFF, 5'h0A, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'h14FFF, 2'd0}, // R7 bit1 ignored
        '{13'h0123, 5'h1A, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 4'h5, 1'b1, 1'b0, 1'b0, 20'h2A123, 2'd0}, // R4
        '{13'h0000, 5'h00, 2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'h20000, 2'd0}, // R5 outer 1
        '{13'h0000, 5'h1F, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'h1E000, 2'd0}, // R5 outer 0
        '{13'h1FFF, 5'h00, 2'b00, 1'b0, 1'b0, 2'b11, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'hC1FFF, 2'd0}, // R6 both
        '{13'h0000, 5'h00, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'h80000, 2'd0}, // R6 line 19
        '{13'h0000, 5'h00, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 20'h40000, 2'd0}, // R6 line 18
        '{13'h0000, 5'h00, 2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 20'h00000, 2'd2}, // R8 low
        '{13'h0000, 5'h00, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 20'h00000, 2'd3}, // R8 high
        '{13'h0000, 5'h00, 2'b01, 1'b0, 1'b0, 2'b00, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 20'h00000, 2'd1}, // R8 two-way
        '{13'h0000, 5'h00, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 20'h00000, 2'd2}, // R9 low
        '{13'h0000, 5'h00, 2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 20'h00000, 2'd3}, // R9 high
        '{13'h0555, 5'h0F, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 4'h3, 1'b1, 1'b0, 1'b0, 20'h06555, 2'd0}  // R4 R5 R2
    };

    task automatic drive(input vec_t v);
        ppu_addr = v.ppu; inner_chr_bank = v.ib; inner_mirr = v.im;
        a17_from_outer = v.a17s; a17_outer_bit = v.a17b; outer_hi = v.hi;
        mirr_ext_en = v.ext; bank_8k = v.b8k; use_8k_bank = v.u8k;
        force_one_screen = v.one; prg_r6_b4 = v.r6;
    endtask

    task automatic check(input string req, input logic [19:0] ea, input logic [1:0] em);
        n_cmp++;
        if (chr_addr !== ea || mirror_sel !== em) begin
            n_bad++;
            $display("FAIL %s: chr_addr=%05h mirror_sel=%0d expected chr_addr=%05h mirror_sel=%0d",
                     req, chr_addr, mirror_sel, ea, em);
        end
    endtask

    initial begin
        // R1: reset with busy inputs
        @(negedge clk);
        drive(VECS[6]);
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", 20'h00000, 2'd0);
        rst_n = 1'b1;

        // Table walk (R2..R9)
        for (int i = 0; i < 15; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R2-table vec %0d", i), VECS[i].exp_addr, VECS[i].exp_mir);
        end

        // Corner: every outer source at once, all ones
        ppu_addr = 13'h1FFF; inner_chr_bank = 5'h00; inner_mirr = 2'b00;
        a17_from_outer = 1'b1; a17_outer_bit = 1'b1; outer_hi = 2'b11;
        bank_8k = 4'hF; use_8k_bank = 1'b1; force_one_screen = 1'b1; prg_r6_b4 = 1'b1;
        mirr_ext_en = 1'b0;
        @(negedge clk);
        check("R4 R5 R6 R9 all outer", 20'hFFFFF, 2'd3);

        // R4: inner bank changes must not reach lines 16..13 in 8 KiB mode
        inner_chr_bank = 5'h0F;
        @(negedge clk);
        check("R4 inner ignored", 20'hFFFFF, 2'd3);

        // R1: reset in mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 20'h00000, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after reset release", 20'hFFFFF, 2'd3);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule